// File: doc/BRIEF.md
# Cache Tag Store with Address Comparator

This block holds the tag and line-status information for one secondary cache. A single line index selects a line in two arrays. The tag array holds the upper address bits of the cached line. The status array holds a valid flag and a few coherence-state bits. Each array has its own write and read enables, so a controller can update the coherence state during a snoop without touching the tag, and the other way round. All writes take effect at the clock edge. Reads are combinational from the index, so data reaches the controller with minimum delay.

In compare mode the bus master drives the address under test onto the tag input bus. The block reads the stored tag of the indexed line internally and compares the two words. It reports a hit only when they are equal and the line is valid. The stored tag is never driven out in this mode. A synchronous reset clears the valid flag of every line in one cycle, so every lookup after start-up misses until a refill writes the line again. Two chip selects of opposite polarity let several instances share one index bus, which gives a deeper cache.

Top module: `tagstore_top`

## Requirements
- R1: The block is selected only when `sel_hi` is 1 and `sel_lo_n` is 0. While it is not selected, `hit`, `tag_out_en` and `st_out_en` are 0, and tag or status writes change nothing.
- R2: When selected, with `cmp_en` at 0 and `rst` at 0, a clock edge with `tag_we` at 1 stores `tag_in` at `line_idx`. With `tag_re` at 1, `tag_out_en` is 1 and `tag_out` shows the stored tag of `line_idx` in the same cycle.
- R3: When selected, with `rst` at 0, a clock edge with `st_we` at 1 stores `st_valid_in` and `st_state_in` at `line_idx`. With `st_re` at 1, `st_out_en` is 1 and `st_valid_out` and `st_state_out` show the stored status in the same cycle.
- R4: `hit` is 1 exactly when the block is selected, `cmp_en` is 1, the valid flag of `line_idx` is set, and the stored tag equals `tag_in`. The result is combinational.
- R5: While `cmp_en` is 1, `tag_out_en` is 0 whatever `tag_re` is, and a `tag_we` pulse is ignored, because `tag_in` then carries the probe address.
- R6: A clock edge with `rst` at 1 clears the valid flag of every line in that one cycle, so every compare afterwards misses. Stored tags and coherence-state bits are kept.
- R7: Tag and status writes presented in a cycle with `rst` at 1 are ignored.
- R8: A refill (tag write plus status write with `st_valid_in` at 1, in one cycle) makes a compare of the same index and tag in the next cycle report a hit.
- R9: A tag write leaves the status of that line unchanged, and a status write leaves the tag unchanged.
- R10: Whenever `tag_out_en` is 0, `tag_out` is all zero. Whenever `st_out_en` is 0, `st_valid_out` and `st_state_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and the valid clear happen at its rising edge |
| rst | input | 1 | Synchronous active-high clear of every valid flag |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| line_idx | input | ADDR_W | Line index shared by both arrays |
| tag_we | input | 1 | Tag write enable |
| tag_re | input | 1 | Tag read enable |
| cmp_en | input | 1 | Compare mode: `tag_in` is a probe address |
| tag_in | input | TAG_W | Tag write data, or the probe address in compare mode |
| tag_out | output | TAG_W | Stored tag, zero when not enabled |
| tag_out_en | output | 1 | Drive enable for `tag_out` |
| hit | output | 1 | Compare result |
| st_we | input | 1 | Status write enable |
| st_re | input | 1 | Status read enable |
| st_valid_in | input | 1 | Valid flag to write |
| st_state_in | input | ST_W | Coherence state to write |
| st_valid_out | output | 1 | Stored valid flag, zero when not enabled |
| st_state_out | output | ST_W | Stored coherence state, zero when not enabled |
| st_out_en | output | 1 | Drive enable for the status outputs |

## Verification
The assertions check the gating on every cycle. A deselected chip raises no enable and no hit, compare mode never enables the tag output, quiet outputs stay at zero, and no lookup hits in the cycle after a clear. They also check that a refill is followed by a hit when the same line and tag are probed at once. Only the bench scenarios show that the stored contents are correct. These cover the full sweep of written tags and states, writes ignored while deselected, in compare mode or during a clear, the independence of the two arrays, and the survival of tags and state across a valid clear.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;

  // Qualified per-cycle operations after chip select, reset and mode gating
  typedef struct packed {
    logic tag_wr;
    logic tag_rd;
    logic st_wr;
    logic st_rd;
    logic cmp;
  } ts_ctl_t;

  function automatic logic chip_on(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction

endpackage

// File: rtl/ts_select.sv
module ts_select
  import tagstore_pkg::*;
(
  input  logic    rst,
  input  logic    sel_hi,
  input  logic    sel_lo_n,
  input  logic    cmp_en,
  input  logic    tag_we,
  input  logic    tag_re,
  input  logic    st_we,
  input  logic    st_re,
  output ts_ctl_t ctl
);

  logic on;

  always_comb begin
    on         = chip_on(sel_hi, sel_lo_n);
    ctl.cmp    = on & cmp_en;
    // the tag bus carries a probe in compare mode: no tag traffic then
    ctl.tag_wr = on & tag_we & ~cmp_en & ~rst;
    ctl.tag_rd = on & tag_re & ~cmp_en;
    ctl.st_wr  = on & st_we & ~rst;
    ctl.st_rd  = on & st_re;
  end

endmodule

// File: rtl/ts_tag_ram.sv
module ts_tag_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/ts_status_ram.sv
module ts_status_ram #(
  parameter int ADDR_W = 10,
  parameter int ST_W   = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wvalid,
  input  logic [ST_W-1:0]   wstate,
  output logic              rvalid,
  output logic [ST_W-1:0]   rstate
);

  localparam int DEPTH = 1 << ADDR_W;

  // valid flags live in flops so they can be cleared together
  logic [DEPTH-1:0] valid_q;
  // coherence state stays in a plain RAM without reset
  logic [ST_W-1:0]  state_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) valid_q <= '0;
    else if (we) valid_q[addr] <= wvalid;
  end

  always_ff @(posedge clk) begin
    if (we) state_mem[addr] <= wstate;
  end

  assign rvalid = valid_q[addr];
  assign rstate = state_mem[addr];

endmodule

// File: rtl/ts_match.sv
module ts_match #(
  parameter int DATA_W = 12
) (
  input  logic              enable,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] probe,
  output logic              hit
);

  assign hit = enable & line_valid & (stored == probe);

endmodule

// File: rtl/tagstore_top.sv
module tagstore_top
  import tagstore_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 12,
  parameter int ST_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic [ADDR_W-1:0] line_idx,
  input  logic              tag_we,
  input  logic              tag_re,
  input  logic              cmp_en,
  input  logic [TAG_W-1:0]  tag_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_out_en,
  output logic              hit,
  input  logic              st_we,
  input  logic              st_re,
  input  logic              st_valid_in,
  input  logic [ST_W-1:0]   st_state_in,
  output logic              st_valid_out,
  output logic [ST_W-1:0]   st_state_out,
  output logic              st_out_en
);

  ts_ctl_t           ctl;
  logic [TAG_W-1:0]  tag_rd;
  logic              val_rd;
  logic [ST_W-1:0]   state_rd;

  ts_select u_sel (
    .rst      (rst),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .cmp_en   (cmp_en),
    .tag_we   (tag_we),
    .tag_re   (tag_re),
    .st_we    (st_we),
    .st_re    (st_re),
    .ctl      (ctl)
  );

  ts_tag_ram #(.ADDR_W(ADDR_W), .DATA_W(TAG_W)) u_tag (
    .clk   (clk),
    .we    (ctl.tag_wr),
    .addr  (line_idx),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  ts_status_ram #(.ADDR_W(ADDR_W), .ST_W(ST_W)) u_stat (
    .clk    (clk),
    .clr    (rst),
    .we     (ctl.st_wr),
    .addr   (line_idx),
    .wvalid (st_valid_in),
    .wstate (st_state_in),
    .rvalid (val_rd),
    .rstate (state_rd)
  );

  ts_match #(.DATA_W(TAG_W)) u_cmp (
    .enable     (ctl.cmp),
    .line_valid (val_rd),
    .stored     (tag_rd),
    .probe      (tag_in),
    .hit        (hit)
  );

  // enable-and-data modelling of the bus drivers; quiet value is zero
  assign tag_out_en   = ctl.tag_rd;
  assign tag_out      = ctl.tag_rd ? tag_rd : '0;
  assign st_out_en    = ctl.st_rd;
  assign st_valid_out = ctl.st_rd & val_rd;
  assign st_state_out = ctl.st_rd ? state_rd : '0;

endmodule

// File: rtl/tagstore_chk.sv
module tagstore_chk #(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 12,
  parameter int ST_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic [ADDR_W-1:0] line_idx,
  input logic              tag_we,
  input logic              tag_re,
  input logic              cmp_en,
  input logic [TAG_W-1:0]  tag_in,
  input logic [TAG_W-1:0]  tag_out,
  input logic              tag_out_en,
  input logic              hit,
  input logic              st_we,
  input logic              st_re,
  input logic              st_valid_in,
  input logic [ST_W-1:0]   st_state_out,
  input logic              st_valid_out,
  input logic              st_out_en
);

  assert_sel_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !(sel_hi && !sel_lo_n) |-> (!hit && !tag_out_en && !st_out_en));

  assert_hit_needs_cmp_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> cmp_en);

  assert_cmp_hidden_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_en |-> !tag_out_en);

  assert_clear_miss_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  assert_refill_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_hi && !sel_lo_n && tag_we && st_we && st_valid_in && !cmp_en)
    |=> (!(sel_hi && !sel_lo_n && cmp_en && line_idx == $past(line_idx)
           && tag_in == $past(tag_in)) || hit));

  assert_quiet_out_R10: assert property (@(posedge clk) disable iff (rst)
    (!tag_out_en |-> tag_out == '0) and
    (!st_out_en |-> (st_state_out == '0 && !st_valid_out)));

endmodule

bind tagstore_top tagstore_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .ST_W(ST_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_hi       (sel_hi),
  .sel_lo_n     (sel_lo_n),
  .line_idx     (line_idx),
  .tag_we       (tag_we),
  .tag_re       (tag_re),
  .cmp_en       (cmp_en),
  .tag_in       (tag_in),
  .tag_out      (tag_out),
  .tag_out_en   (tag_out_en),
  .hit          (hit),
  .st_we        (st_we),
  .st_re        (st_re),
  .st_valid_in  (st_valid_in),
  .st_state_out (st_state_out),
  .st_valid_out (st_valid_out),
  .st_out_en    (st_out_en)
);

// File: tb/tagstore_top_tb.sv
module tagstore_top_tb;

  localparam int AW = 4;
  localparam int TW = 6;
  localparam int SW = 2;
  localparam int N  = 1 << AW;

  logic          clk = 0;
  logic          rst, sel_hi, sel_lo_n, tag_we, tag_re, cmp_en;
  logic          st_we, st_re, st_valid_in;
  logic [AW-1:0] line_idx;
  logic [TW-1:0] tag_in, tag_out;
  logic [SW-1:0] st_state_in, st_state_out;
  logic          tag_out_en, hit, st_valid_out, st_out_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [TW-1:0] mtag [N];
  logic          mval [N];
  logic [SW-1:0] mst  [N];

  always #2 clk = ~clk;

  tagstore_top #(.ADDR_W(AW), .TAG_W(TW), .ST_W(SW)) u_dut (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .line_idx(line_idx), .tag_we(tag_we), .tag_re(tag_re), .cmp_en(cmp_en),
    .tag_in(tag_in), .tag_out(tag_out), .tag_out_en(tag_out_en), .hit(hit),
    .st_we(st_we), .st_re(st_re), .st_valid_in(st_valid_in),
    .st_state_in(st_state_in), .st_valid_out(st_valid_out),
    .st_state_out(st_state_out), .st_out_en(st_out_en)
  );

  function automatic logic [TW-1:0] tg(input int a);
    return TW'((a * 5 + 3) % 64);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_hi = 1; sel_lo_n = 0; tag_we = 0; tag_re = 0; cmp_en = 0;
    st_we = 0; st_re = 0; st_valid_in = 0; st_state_in = '0; tag_in = '0;
  endtask

  task automatic read_line(input int a, input string req);
    @(negedge clk); idle(); line_idx = AW'(a); tag_re = 1; st_re = 1; #1;
    chk(int'(tag_out), int'(mtag[a]), {req, " tag"});
    chk(int'(st_valid_out), int'(mval[a]), {req, " valid"});
    chk(int'(st_state_out), int'(mst[a]), {req, " state"});
  endtask

  task automatic probe(input int a, input logic [TW-1:0] t, input int exp, input string req);
    @(negedge clk); idle(); line_idx = AW'(a); cmp_en = 1; tag_in = t; #1;
    chk(int'(hit), exp, req);
  endtask

  initial begin
    idle(); rst = 1; line_idx = '0;
    @(negedge clk); @(negedge clk); #1;
    chk(int'(hit), 0, "R1 reset hit");
    chk(int'(tag_out_en), 0, "R10 reset tag_out_en");
    rst = 0;
    for (int a = 0; a < N; a++) mval[a] = 0;

    // R6: every line misses after clear
    for (int a = 0; a < N; a++) probe(a, tg(a), 0, "R6 miss after clear");

    // fill every line (refill form: tag and status together)
    for (int a = 0; a < N; a++) begin
      @(negedge clk); idle(); line_idx = AW'(a);
      tag_we = 1; tag_in = tg(a); st_we = 1; st_valid_in = 1; st_state_in = SW'(a % 4);
      mtag[a] = tg(a); mval[a] = 1; mst[a] = SW'(a % 4);
    end

    for (int a = 0; a < N; a++) begin
      read_line(a, "R2 R3 readback");
      chk(int'(tag_out_en), 1, "R2 tag_out_en");
      chk(int'(st_out_en), 1, "R3 st_out_en");
      probe(a, tg(a), 1, "R4 hit");
      tag_re = 1; #1;
      chk(int'(tag_out_en), 0, "R5 no drive in compare");
      chk(int'(tag_out), 0, "R10 quiet tag_out");
      tag_in = tg(a) ^ 6'h01; #1;
      chk(int'(hit), 0, "R4 wrong tag miss");
      tag_in = tg(a); sel_hi = 0; st_re = 1; #1;
      chk(int'(hit), 0, "R1 sel_hi low");
      chk(int'(st_out_en), 0, "R1 st_out_en");
      chk(int'(st_state_out), 0, "R10 quiet state");
      sel_hi = 1; sel_lo_n = 1; #1;
      chk(int'(hit), 0, "R1 sel_lo_n high");
    end

    // R1: writes ignored while deselected
    @(negedge clk); idle(); line_idx = 2; sel_lo_n = 1;
    tag_we = 1; tag_in = ~tg(2); st_we = 1; st_valid_in = 0; st_state_in = 2'd3;
    read_line(2, "R1 write ignored");

    // R5: tag write ignored during compare
    @(negedge clk); idle(); line_idx = 4; cmp_en = 1; tag_we = 1; tag_in = 6'h3f;
    read_line(4, "R5 write in compare ignored");

    // R9: tag-only write keeps status; status-only write keeps tag
    @(negedge clk); idle(); line_idx = 6; tag_we = 1; tag_in = 6'h15; mtag[6] = 6'h15;
    read_line(6, "R9 tag-only write");
    probe(6, 6'h15, 1, "R9 new tag hits");
    @(negedge clk); idle(); line_idx = 7; st_we = 1; st_valid_in = 0; st_state_in = 2'd3;
    mval[7] = 0; mst[7] = 2'd3;
    read_line(7, "R9 status-only write");
    probe(7, mtag[7], 0, "R9 invalidated line misses");

    // R7 / R6: clear with writes presented in the same cycle
    @(negedge clk); idle(); rst = 1; line_idx = 8; tag_we = 1; tag_in = 6'h2e;
    st_we = 1; st_valid_in = 1; st_state_in = 2'd0;
    @(negedge clk); rst = 0; idle();
    for (int a = 0; a < N; a++) mval[a] = 0;
    for (int a = 0; a < N; a++) probe(a, mtag[a], 0, "R6 all miss after clear");
    read_line(8, "R7 writes during clear ignored");
    read_line(9, "R6 tags and state kept");

    // R8: refill then immediate hit
    @(negedge clk); idle(); line_idx = 5; tag_we = 1; tag_in = 6'h2a;
    st_we = 1; st_valid_in = 1; st_state_in = 2'd2;
    mtag[5] = 6'h2a; mval[5] = 1; mst[5] = 2'd2;
    probe(5, 6'h2a, 1, "R8 hit after refill");
    probe(10, mtag[10], 0, "R8 other line still misses");
    read_line(5, "R8 refill contents");

    @(negedge clk); idle(); #1;
    chk(int'(tag_out), 0, "R10 idle tag_out");
    chk(int'(st_valid_out), 0, "R10 idle valid");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule